// File: doc/BRIEF.md
# Burst Read Sequencer with Checksum

This block adds a streaming read mode to the serial slave port of a motion-sensor front end. The port uses SPI mode 3: the clock idles high, the slave changes its output on falling edges and the host samples on rising edges. A host pulls chip select low and shifts in one 16-bit trigger word, 0x6800. The block then sends ten 16-bit words back to back on the data-out line, most significant bit first, with no gap between words. The first nine words are status, three angular-rate axes, three acceleration axes, temperature and one selectable word. The tenth is an additive checksum. The block samples the serial pins with the system clock, so SCLK runs well below the system clock rate.

A sample strobe loads the incoming sensor words and a timestamp into a holding bank. When the trigger word is decoded, the block copies the holding bank into a snapshot, and the stream reads only from that snapshot. The sync-mode code present at that moment decides whether the ninth word is the sample counter or the timestamp. The block computes the checksum in the same cycle, from the values that will be sent.

Top module: `burst_seq`

## Requirements
- R1: After reset, while chip select is high, and during every command word, `spi_miso` is 0.
- R2: When the 16 bits received on `spi_mosi` in one command slot equal 0x6800, the MSB of the first response word appears on `spi_miso` after the next falling SCLK edge.
- R3: The response is ten 16-bit words, MSB first, with no idle bits between words, in this order: word index 0 (status), 1 to 3 (rate X, Y, Z), 4 to 6 (acceleration X, Y, Z), 7 (temperature), 8 (ninth word), 9 (checksum). Word index i of the stream is taken from bits [16*i+15:16*i] of `sense_words` for i from 0 to 7.
- R4: The ninth word is the timestamp when `sync_mode` equals 3'b010 at burst start. For any other code it is `sense_words[143:128]`, the counter. A change of `sync_mode` after burst start does not affect the stream.
- R5: The checksum word is the 16-bit sum of the 18 bytes of words 0 to 8, each byte taken as an unsigned 8-bit value. All nine words equal to 0xFFFF give 0x11EE.
- R6: A `sample_stb` pulse loads `sense_words` and `stamp_word` into the holding bank. A burst streams the holding-bank contents present at its start. A strobe during a burst leaves that burst unchanged and is seen by the next burst.
- R7: Raising chip select mid-burst ends the burst. The next chip-select-low period starts again with command decoding.
- R8: A command word other than 0x6800 produces no response, and decoding continues with the next 16 bits of the same frame. After the checksum word, decoding resumes, so a second 0x6800 in the same frame starts a new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idle high |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| sample_stb | input | 1 | Loads the sensor words and timestamp into the holding bank |
| sync_mode | input | 3 | Clock-sync mode code; 3'b010 selects the timestamp as ninth word |
| sense_words | input | 144 | Nine 16-bit words: status, rate X/Y/Z, accel X/Y/Z, temperature, counter |
| stamp_word | input | 16 | Timestamp word |

## Verification
The hardest case to reach from the ports is a sample update that lands inside a running burst. It takes a strobe, with new words and a new sync-mode code, timed between serial clock edges in the middle of the stream. The bench splits one burst into two read phases. Between them it changes every sensor word, the timestamp and the mode, and it pulses the strobe. The remaining words must still match the old snapshot and the old ninth-word choice, and a following burst must show the new data. The bench also reaches abort, rejected-command and back-to-back bursts inside one frame by ordering command words within a single chip-select period.

// File: rtl/burst_pkg.sv
package burst_pkg;
   typedef enum logic {
      BS_CMD  = 1'b0,
      BS_RESP = 1'b1
   } bseq_state_t;

   localparam logic [2:0] PIN_RESET = 3'b110; // {cs_n, sclk, mosi} idle values
endpackage

// File: rtl/bseq_pinsync.sv
module bseq_pinsync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sclk,
   input  logic mosi,
   output logic cs_hi,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic mosi_s
);
   import burst_pkg::*;

   logic [2:0] raw;
   logic [2:0] synced;
   logic       sclk_prev;

   assign raw = {cs_n, sclk, mosi};

   generate
      if (STAGES > 0) begin : g_sync
         logic [2:0] chain [STAGES];
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= PIN_RESET;
               else if (i == 0) chain[i] <= raw;
               else chain[i] <= chain[(i == 0) ? 0 : i - 1];
            end
         end
         assign synced = chain[STAGES-1];
      end else begin : g_direct
         assign synced = raw;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev <= 1'b1;
      else        sclk_prev <= synced[1];
   end

   assign cs_hi     = synced[2];
   assign mosi_s    = synced[0];
   assign sclk_rise = synced[1] & ~sclk_prev;
   assign sclk_fall = ~synced[1] & sclk_prev;
endmodule

// File: rtl/bseq_snap.sv
module bseq_snap #(
   parameter int         WORD_W      = 16,
   parameter int         N_DATA      = 9,
   parameter int         MODE_W      = 3,
   parameter logic [2:0] SCALED_CODE = 3'b010,
   localparam int        N_WORDS     = N_DATA + 1,
   localparam int        WIDX_W      = $clog2(N_WORDS),
   localparam int        BYTES       = WORD_W / 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        strobe,
   input  logic [N_DATA*WORD_W-1:0]    words_in,
   input  logic [WORD_W-1:0]           ts_in,
   input  logic [MODE_W-1:0]           mode,
   input  logic                        capture,
   input  logic [WIDX_W-1:0]           sel,
   output logic [WORD_W-1:0]           word_out,
   output logic [N_WORDS*WORD_W-1:0]   snap_flat
);
   logic [WORD_W-1:0] hold    [N_DATA];
   logic [WORD_W-1:0] hold_ts;
   logic [WORD_W-1:0] pick    [N_DATA];
   logic [WORD_W-1:0] snap    [N_WORDS];
   logic [WORD_W-1:0] sum;
   logic              scaled;

   assign scaled = (mode == MODE_W'(SCALED_CODE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_DATA; i++) hold[i] <= '0;
         hold_ts <= '0;
      end else if (strobe) begin
         for (int i = 0; i < N_DATA; i++) hold[i] <= words_in[i*WORD_W +: WORD_W];
         hold_ts <= ts_in;
      end
   end

   always_comb begin
      for (int i = 0; i < N_DATA; i++) pick[i] = hold[i];
      if (scaled) pick[N_DATA-1] = hold_ts;
   end

   always_comb begin
      sum = '0;
      for (int i = 0; i < N_DATA; i++)
         for (int b = 0; b < BYTES; b++)
            sum = sum + WORD_W'(pick[i][b*8 +: 8]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_WORDS; i++) snap[i] <= '0;
      end else if (capture) begin
         for (int i = 0; i < N_DATA; i++) snap[i] <= pick[i];
         snap[N_DATA] <= sum;
      end
   end

   assign word_out = snap[sel];

   generate
      for (genvar i = 0; i < N_WORDS; i++) begin : g_flat
         assign snap_flat[i*WORD_W +: WORD_W] = snap[i];
      end
   endgenerate
endmodule

// File: rtl/bseq_fsm.sv
module bseq_fsm #(
   parameter int          WORD_W    = 16,
   parameter int          N_WORDS   = 10,
   parameter logic [15:0] BURST_CMD = 16'h6800,
   localparam int         BIT_W     = $clog2(WORD_W),
   localparam int         WIDX_W    = $clog2(N_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_hi,
   input  logic              rise,
   input  logic              fall,
   input  logic              mosi_s,
   input  logic [WORD_W-1:0] word_in,
   output logic              capture,
   output logic              in_resp,
   output logic [WIDX_W-1:0] widx,
   output logic [BIT_W-1:0]  bidx,
   output logic              miso
);
   import burst_pkg::*;

   bseq_state_t       st;
   logic [WORD_W-1:0] shreg;
   logic [WORD_W-1:0] next_cmd;
   logic              miso_q;
   logic              last_bit;
   logic              last_word;
   logic [BIT_W-1:0]  out_pos;

   assign next_cmd  = {shreg[WORD_W-2:0], mosi_s};
   assign last_bit  = (bidx == BIT_W'(WORD_W-1));
   assign last_word = (widx == WIDX_W'(N_WORDS-1));
   assign out_pos   = BIT_W'(WORD_W-1) - bidx;
   assign capture   = !cs_hi && rise && (st == BS_CMD) && last_bit &&
                      (next_cmd == WORD_W'(BURST_CMD));
   assign in_resp   = (st == BS_RESP);
   assign miso      = in_resp & miso_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= BS_CMD; shreg <= '0; bidx <= '0; widx <= '0; miso_q <= 1'b0;
      end else if (cs_hi) begin
         st <= BS_CMD; shreg <= '0; bidx <= '0; widx <= '0; miso_q <= 1'b0;
      end else if (rise) begin
         bidx <= last_bit ? '0 : bidx + 1'b1;
         if (st == BS_CMD) begin
            shreg <= next_cmd;
            if (capture) begin
               st     <= BS_RESP;
               widx   <= '0;
               miso_q <= 1'b0;
            end
         end else if (last_bit) begin
            if (last_word) begin
               st   <= BS_CMD;
               widx <= '0;
            end else begin
               widx <= widx + 1'b1;
            end
         end
      end else if (fall && st == BS_RESP) begin
         miso_q <= word_in[out_pos];
      end
   end
endmodule

// File: rtl/burst_seq.sv
module burst_seq #(
   parameter int          WORD_W      = 16,
   parameter int          N_DATA      = 9,
   parameter int          MODE_W      = 3,
   parameter int          SYNC_STAGES = 2,
   parameter logic [15:0] BURST_CMD   = 16'h6800,
   parameter logic [2:0]  SCALED_CODE = 3'b010
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     spi_cs_n,
   input  logic                     spi_sclk,
   input  logic                     spi_mosi,
   output logic                     spi_miso,
   input  logic                     sample_stb,
   input  logic [MODE_W-1:0]        sync_mode,
   input  logic [N_DATA*WORD_W-1:0] sense_words,
   input  logic [WORD_W-1:0]        stamp_word
);
   localparam int     N_WORDS  = N_DATA + 1;
   localparam int     WIDX_W   = $clog2(N_WORDS);
   localparam int     BIT_W    = $clog2(WORD_W);
   localparam longint MAX_SUM  = longint'(N_DATA) * (WORD_W / 8) * 255;

   generate
      if (WORD_W % 8 != 0 || (1 << BIT_W) != WORD_W) begin : g_bad_width
         $error("burst_seq: WORD_W must be a power of two and a whole number of bytes");
      end
      if (MAX_SUM >= (longint'(1) << WORD_W)) begin : g_bad_sum
         $error("burst_seq: checksum would overflow WORD_W");
      end
      if (N_DATA < 2 || MODE_W > 3 || MODE_W < 1) begin : g_bad_cfg
         $error("burst_seq: unsupported N_DATA or MODE_W");
      end
   endgenerate

   logic              cs_hi_s, sclk_rise, sclk_fall, mosi_s;
   logic              capture, in_resp;
   logic [WIDX_W-1:0] widx;
   logic [BIT_W-1:0]  bidx;
   logic [WORD_W-1:0] cur_word;
   logic [N_WORDS*WORD_W-1:0] snap_flat;

   bseq_pinsync #(.STAGES(SYNC_STAGES)) u_pins (
      .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi),
      .cs_hi(cs_hi_s), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_s(mosi_s)
   );

   bseq_snap #(
      .WORD_W(WORD_W), .N_DATA(N_DATA), .MODE_W(MODE_W), .SCALED_CODE(SCALED_CODE)
   ) u_snap (
      .clk(clk), .rst_n(rst_n), .strobe(sample_stb), .words_in(sense_words),
      .ts_in(stamp_word), .mode(sync_mode), .capture(capture), .sel(widx),
      .word_out(cur_word), .snap_flat(snap_flat)
   );

   bseq_fsm #(
      .WORD_W(WORD_W), .N_WORDS(N_WORDS), .BURST_CMD(BURST_CMD)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi_s), .rise(sclk_rise), .fall(sclk_fall),
      .mosi_s(mosi_s), .word_in(cur_word), .capture(capture), .in_resp(in_resp),
      .widx(widx), .bidx(bidx), .miso(spi_miso)
   );
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
   parameter int WORD_W  = 16,
   parameter int N_WORDS = 10,
   localparam int WIDX_W = $clog2(N_WORDS),
   localparam int BIT_W  = $clog2(WORD_W)
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       cs_hi,
   input logic                       rise,
   input logic                       in_resp,
   input logic [WIDX_W-1:0]          widx,
   input logic [BIT_W-1:0]           bidx,
   input logic [N_WORDS*WORD_W-1:0]  snap
);
   // R7: chip select high always returns to an empty command slot
   a_r7_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
      cs_hi |=> (!in_resp && widx == '0 && bidx == '0));

   // R2: a burst is only entered on a sampled rising serial clock edge
   a_r2_entry_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_resp) |-> $past(rise));

   // R6: snapshot never changes while a burst is streaming
   a_r6_snapshot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (in_resp && $past(in_resp)) |-> $stable(snap));

   // R3: the burst ends after the last bit of the checksum word
   a_r3_ends_after_sum: assert property (@(posedge clk) disable iff (!rst_n)
      (in_resp && rise && !cs_hi && bidx == BIT_W'(WORD_W-1) &&
       widx == WIDX_W'(N_WORDS-1)) |=> !in_resp);
endmodule

bind burst_seq burst_seq_chk #(.WORD_W(WORD_W), .N_WORDS(N_DATA + 1)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi_s), .rise(sclk_rise),
   .in_resp(in_resp), .widx(widx), .bidx(bidx), .snap(snap_flat)
);

// File: tb/sim_burst_seq.sv
module sim_burst_seq;
   localparam int WW = 16;
   localparam int ND = 9;

   // row: [0] mode code, [1..9] sensor words (9th = counter), [10] timestamp
   localparam logic [15:0] TBL [4][11] = '{
      '{16'h0000, 16'h0001, 16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 16'h0F0F, 16'hF0F0, 16'h00FF, 16'h002A, 16'h7777},
      '{16'h0002, 16'hA5A5, 16'h8000, 16'h7FFF, 16'h0001, 16'hFFFE, 16'h1111, 16'h2222, 16'h3333, 16'h0044, 16'hBEEF},
      '{16'h0005, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF},
      '{16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_cs_n = 1'b1;
   logic spi_sclk = 1'b1;
   logic spi_mosi = 1'b0;
   logic spi_miso;
   logic sample_stb = 1'b0;
   logic [2:0] sync_mode = 3'b000;
   logic [ND*WW-1:0] sense_words = '0;
   logic [WW-1:0] stamp_word = '0;

   int total = 0;
   int bad = 0;
   logic [15:0] cur_w [ND];
   logic [15:0] cur_ts;
   logic [15:0] exp_w [10];
   logic [15:0] g;

   always #2 clk = ~clk;

   burst_seq u0 (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .sample_stb(sample_stb),
      .sync_mode(sync_mode), .sense_words(sense_words), .stamp_word(stamp_word)
   );

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic set_expect(input logic [2:0] m);
      logic [15:0] s;
      s = '0;
      for (int i = 0; i < 8; i++) exp_w[i] = cur_w[i];
      exp_w[8] = (m == 3'b010) ? cur_ts : cur_w[8];
      for (int i = 0; i < 9; i++)
         s = s + {8'h00, exp_w[i][15:8]} + {8'h00, exp_w[i][7:0]};
      exp_w[9] = s;
   endtask

   task automatic apply_sample();
      @(negedge clk);
      for (int i = 0; i < ND; i++) sense_words[i*WW +: WW] = cur_w[i];
      stamp_word = cur_ts;
      sample_stb = 1'b1;
      @(negedge clk);
      sample_stb = 1'b0;
   endtask

   task automatic xfer(input logic [15:0] din, output logic [15:0] dout);
      for (int i = 15; i >= 0; i--) begin
         @(negedge clk);
         spi_sclk = 1'b0;
         spi_mosi = din[i];
         repeat (7) @(negedge clk);
         dout[i] = spi_miso;
         spi_sclk = 1'b1;
         repeat (7) @(negedge clk);
      end
   endtask

   task automatic frame_begin();
      @(negedge clk);
      spi_cs_n = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic frame_end();
      @(negedge clk);
      spi_cs_n = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   task automatic read_range(input int lo, input int hi, input string ctx);
      logic [15:0] r;
      for (int k = lo; k <= hi; k++) begin
         xfer(16'h0000, r);
         if (k == 0)      chk($sformatf("R2 first word (%s)", ctx), r, exp_w[k]);
         else if (k == 8) chk($sformatf("R4 ninth word (%s)", ctx), r, exp_w[k]);
         else if (k == 9) chk($sformatf("R5 checksum (%s)", ctx), r, exp_w[k]);
         else             chk($sformatf("R3 word %0d (%s)", k, ctx), r, exp_w[k]);
      end
   endtask

   initial begin
      logic [15:0] got;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1 miso after reset", {15'b0, spi_miso}, 16'h0000);

      // table of stimulus rows
      for (int r = 0; r < 4; r++) begin
         sync_mode = TBL[r][0][2:0];
         for (int i = 0; i < ND; i++) cur_w[i] = TBL[r][1+i];
         cur_ts = TBL[r][10];
         apply_sample();
         set_expect(TBL[r][0][2:0]);
         frame_begin();
         xfer(16'h6800, got);
         chk($sformatf("R1 command slot quiet row %0d", r), got, 16'h0000);
         read_range(0, 9, $sformatf("row %0d", r));
         frame_end();
      end
      chk("R5 max byte sum reference", exp_w[9], 16'h11EE);

      // R6/R4: strobe and mode change in the middle of a burst
      sync_mode = 3'b000;
      for (int i = 0; i < ND; i++) cur_w[i] = 16'h0101 * (i + 1);
      cur_ts = 16'h5A5A;
      apply_sample();
      set_expect(3'b000);
      frame_begin();
      xfer(16'h6800, got);
      read_range(0, 3, "R6 before strobe");
      for (int i = 0; i < ND; i++) cur_w[i] = 16'hC000 + 16'(i);
      cur_ts = 16'h1357;
      sync_mode = 3'b010;
      apply_sample();
      read_range(4, 9, "R6 after mid-burst strobe");
      frame_end();
      set_expect(3'b010);
      frame_begin();
      xfer(16'h6800, got);
      read_range(0, 9, "R6 next burst sees new data");
      frame_end();

      // R7: abort by chip select, then a clean burst
      frame_begin();
      xfer(16'h6800, got);
      read_range(0, 2, "R7 partial");
      frame_end();
      frame_begin();
      xfer(16'h6800, got);
      chk("R7 command slot after abort", got, 16'h0000);
      read_range(0, 9, "R7 after abort");
      frame_end();

      // R8: rejected command, then burst, then back-to-back burst in one frame
      frame_begin();
      xfer(16'h7200, got);
      chk("R8 other command quiet", got, 16'h0000);
      xfer(16'h6800, got);
      chk("R8 slot after other command quiet", got, 16'h0000);
      read_range(0, 9, "R8 after rejected command");
      xfer(16'h6800, got);
      chk("R8 second trigger slot quiet", got, 16'h0000);
      read_range(0, 9, "R8 back-to-back burst");
      frame_end();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired got=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule